// File: doc/BRIEF.md
# Memory barrier ordering controller

This block sits between the in-order issue stage of a processor core and its memory interface. It counts the loads, stores and cache or TLB maintenance operations that have been issued and not yet acknowledged. It keeps a separate count for each shareability domain. When a barrier is issued, the block records the barrier's kind, access class and domain. It then holds back the classes of later operations that the barrier orders, until every earlier operation the barrier depends on has been acknowledged.

The issue stage presents one operation per cycle, together with its type code and its domain. The block answers combinationally with one issue enable per operation class and a global stall for the operation being presented. Memory returns completion acknowledgements, each tagged with a class and a domain. An instruction synchronization barrier also raises a one-cycle flush request so that the front end fetches again. Caches, the interconnect, address translation and any real reordering of transactions are outside the block.

Top module: `membar_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all outstanding counters and any pending barrier. After reset, `ld_en`, `st_en`, `mnt_en`, `oth_en` and `bar_en` are all 1, and `stall` and `flush` are 0.
- R2: A data barrier with access class code 0 (load first) waits for earlier loads but not for earlier stores. While it is pending, `ld_en` and `st_en` are both 0.
- R3: A data barrier with access class code 1 (store only) waits for earlier stores but not for earlier loads. While it is pending, `st_en` is 0 and `ld_en` stays 1.
- R4: A data barrier with access class code 2 (any) waits for both earlier loads and earlier stores. While it is pending, `ld_en` and `st_en` are 0.
- R5: The domain codes are 0 non-shareable, 1 inner, 2 outer and 3 full system. A data barrier in domain d waits only on counters of domains 0 to d, so a full-system barrier waits on every domain.
- R6: A data memory barrier (kind code 0) also waits for earlier maintenance operations in its covered domains. `oth_en` stays 1 while it is pending.
- R7: A data synchronization barrier (kind code 1) has the same ordering and maintenance waits as kind 0. In addition, it holds `oth_en` at 0 while it is pending.
- R8: An instruction synchronization barrier (kind code 2) ignores its class and domain fields. It waits for outstanding maintenance in every domain and holds every enable at 0 while it is pending. It raises `flush` for exactly one cycle, in the cycle after the cycle in which it completes.
- R9: Only one barrier can be pending at a time, and `bar_en` is 0 while one is. `stall` is 1 exactly when `iss_valid` is 1 and the enable for the presented operation is 0. A stalled operation is not counted and not recorded.
- R10: An acknowledgement decrements the counter for its class and domain. If an accepted issue targets the same counter in the same cycle, the counter is unchanged. A barrier becomes pending in the cycle after it is accepted. The enables return in the cycle after the first pending cycle in which its counters are all zero.
- R11: Each counter is CNT_W bits wide. It holds at 2^CNT_W-1 when further issues arrive, and it holds at 0 when an acknowledgement arrives with nothing outstanding.
- R12: The operation codes are 0 other, 1 load, 2 store, 3 maintenance and 4 barrier; codes 5 to 7 act as other. Access class code 3 acts as code 2, and kind code 3 acts as kind 1. The acknowledgement class codes are 0 load, 1 store and 2 maintenance; code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_op | input | 3 | Operation type code |
| iss_dom | input | 2 | Shareability domain of the operation or barrier |
| bar_kind | input | 2 | Barrier kind (0 memory, 1 synchronization, 2 instruction sync) |
| bar_class | input | 2 | Barrier access class (0 load, 1 store, 2 any) |
| ack_valid | input | 1 | A completion acknowledgement is present |
| ack_class | input | 2 | Class of the acknowledged operation |
| ack_dom | input | 2 | Domain of the acknowledged operation |
| ld_en | output | 1 | Loads may issue |
| st_en | output | 1 | Stores may issue |
| mnt_en | output | 1 | Maintenance operations may issue |
| oth_en | output | 1 | Non-memory operations may issue |
| bar_en | output | 1 | A barrier may issue |
| stall | output | 1 | The presented operation is held |
| flush | output | 1 | One-cycle pipeline flush request |

## Verification
Two events can fall in the same cycle: an accepted issue that raises a counter, and an acknowledgement that lowers the same counter. The bench provokes this by presenting a load and acknowledging a load of the same domain in one cycle, with one load already outstanding. It then issues a load-class barrier and checks that the barrier is still waiting on one acknowledgement, and that it releases only after that one arrives. A second collision comes from the barrier-completion cycle: it checks that a barrier presented behind a pending one is stalled and is accepted once the first has released. A behavioural model in the bench predicts every output in every cycle.

// File: rtl/membar_pkg.sv
package membar_pkg;

    localparam int NUM_DOM = 4;
    localparam int DOM_W   = 2;
    localparam int NUM_CLS = 3;
    localparam int CLS_W   = 2;

    localparam int CL_LOAD  = 0;
    localparam int CL_STORE = 1;
    localparam int CL_MAINT = 2;

    typedef enum logic [2:0] {
        OP_OTHER = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_MAINT = 3'd3,
        OP_BAR   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        BK_DMB = 2'd0,
        BK_DSB = 2'd1,
        BK_ISB = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        AC_LD  = 2'd0,
        AC_ST  = 2'd1,
        AC_ANY = 2'd2
    } acc_e;

    typedef struct packed {
        logic             busy;
        kind_e            kind;
        acc_e             acc;
        logic [DOM_W-1:0] dom;
    } bar_t;

    function automatic op_e op_norm(input logic [2:0] raw);
        case (raw)
            3'd1:    return OP_LOAD;
            3'd2:    return OP_STORE;
            3'd3:    return OP_MAINT;
            3'd4:    return OP_BAR;
            default: return OP_OTHER;
        endcase
    endfunction

    function automatic kind_e kind_norm(input logic [1:0] raw);
        case (raw)
            2'd0:    return BK_DMB;
            2'd2:    return BK_ISB;
            default: return BK_DSB;
        endcase
    endfunction

    function automatic acc_e acc_norm(input logic [1:0] raw);
        case (raw)
            2'd0:    return AC_LD;
            2'd1:    return AC_ST;
            default: return AC_ANY;
        endcase
    endfunction

    // Counter classes a pending barrier has to drain.
    function automatic logic [NUM_CLS-1:0] wait_mask(input kind_e k, input acc_e a);
        logic [NUM_CLS-1:0] m;
        m = '0;
        m[CL_MAINT] = 1'b1;
        if (k != BK_ISB) begin
            m[CL_LOAD]  = (a != AC_ST);
            m[CL_STORE] = (a != AC_LD);
        end
        return m;
    endfunction

    // Whether counters of domain d are inside the barrier's reach.
    function automatic logic dom_covered(input kind_e k, input logic [DOM_W-1:0] bd,
                                         input logic [DOM_W-1:0] d);
        return (k == BK_ISB) || (d <= bd);
    endfunction

endpackage

// File: rtl/membar_sat_cnt.sv
module membar_sat_cnt #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic zero
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (inc && !dec && q != MAX)
            q <= q + 1'b1;
        else if (dec && !inc && q != '0)
            q <= q - 1'b1;
    end

    assign zero = (q == '0);

    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (q == MAX && inc && !dec) |=> (q == MAX));

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        (q == '0 && dec && !inc) |=> (q == '0));

    assert_collide_R10: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(q));
endmodule

// File: rtl/membar_track.sv
module membar_track
    import membar_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             inc_v,
    input  logic [CLS_W-1:0]                 inc_cls,
    input  logic [DOM_W-1:0]                 inc_dom,
    input  logic                             dec_v,
    input  logic [CLS_W-1:0]                 dec_cls,
    input  logic [DOM_W-1:0]                 dec_dom,
    output logic [NUM_DOM-1:0][NUM_CLS-1:0]  idle
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            logic hit_inc, hit_dec;
            assign hit_inc = inc_v && (inc_cls == CLS_W'(c)) && (inc_dom == DOM_W'(d));
            assign hit_dec = dec_v && (dec_cls == CLS_W'(c)) && (dec_dom == DOM_W'(d));
            membar_sat_cnt #(.W(CNT_W)) u_cnt (
                .clk  (clk),
                .rst  (rst),
                .inc  (hit_inc),
                .dec  (hit_dec),
                .zero (idle[d][c])
            );
        end
    end
endmodule

// File: rtl/membar_gate.sv
module membar_gate
    import membar_pkg::*;
(
    input  bar_t pend,
    output logic ld_en,
    output logic st_en,
    output logic mnt_en,
    output logic oth_en,
    output logic bar_en
);
    always_comb begin
        ld_en  = !pend.busy || (pend.kind != BK_ISB && pend.acc == AC_ST);
        st_en  = !pend.busy;
        mnt_en = !pend.busy;
        bar_en = !pend.busy;
        oth_en = !pend.busy || (pend.kind == BK_DMB);
    end
endmodule

// File: rtl/membar_ctrl.sv
module membar_ctrl
    import membar_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       iss_valid,
    input  logic [2:0] iss_op,
    input  logic [1:0] iss_dom,
    input  logic [1:0] bar_kind,
    input  logic [1:0] bar_class,
    input  logic       ack_valid,
    input  logic [1:0] ack_class,
    input  logic [1:0] ack_dom,
    output logic       ld_en,
    output logic       st_en,
    output logic       mnt_en,
    output logic       oth_en,
    output logic       bar_en,
    output logic       stall,
    output logic       flush
);
    bar_t pend;
    op_e  op;
    logic op_ok, accept, done, blocked;
    logic inc_v, dec_v;
    logic [CLS_W-1:0] inc_cls;
    logic [NUM_DOM-1:0][NUM_CLS-1:0] idle;
    logic [NUM_CLS-1:0] mask;

    membar_gate u_gate (
        .pend   (pend),
        .ld_en  (ld_en),
        .st_en  (st_en),
        .mnt_en (mnt_en),
        .oth_en (oth_en),
        .bar_en (bar_en)
    );

    always_comb begin
        op = op_norm(iss_op);
        case (op)
            OP_LOAD:  begin op_ok = ld_en;  inc_cls = CLS_W'(CL_LOAD);  end
            OP_STORE: begin op_ok = st_en;  inc_cls = CLS_W'(CL_STORE); end
            OP_MAINT: begin op_ok = mnt_en; inc_cls = CLS_W'(CL_MAINT); end
            OP_BAR:   begin op_ok = bar_en; inc_cls = '0;               end
            default:  begin op_ok = oth_en; inc_cls = '0;               end
        endcase
        accept = iss_valid && op_ok;
        stall  = iss_valid && !op_ok;
        inc_v  = accept && (op == OP_LOAD || op == OP_STORE || op == OP_MAINT);
        dec_v  = ack_valid && (ack_class != 2'd3);
    end

    membar_track #(.CNT_W(CNT_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .inc_v   (inc_v),
        .inc_cls (inc_cls),
        .inc_dom (iss_dom),
        .dec_v   (dec_v),
        .dec_cls (ack_class),
        .dec_dom (ack_dom),
        .idle    (idle)
    );

    always_comb begin
        mask    = wait_mask(pend.kind, pend.acc);
        blocked = 1'b0;
        for (int d = 0; d < NUM_DOM; d++) begin
            for (int c = 0; c < NUM_CLS; c++) begin
                if (mask[c] && dom_covered(pend.kind, pend.dom, DOM_W'(d)) && !idle[d][c])
                    blocked = 1'b1;
            end
        end
        done = pend.busy && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '{busy: 1'b0, kind: BK_DMB, acc: AC_LD, dom: '0};
            flush <= 1'b0;
        end else begin
            flush <= done && (pend.kind == BK_ISB);
            if (done)
                pend.busy <= 1'b0;
            else if (accept && op == OP_BAR)
                pend <= '{busy: 1'b1, kind: kind_norm(bar_kind),
                          acc: acc_norm(bar_class), dom: iss_dom};
        end
    end

    assert_one_barrier_R9: assert property (@(posedge clk) disable iff (rst)
        pend.busy |-> !(iss_valid && iss_op == 3'd4 && !stall));

    assert_sync_blocks_other_R7: assert property (@(posedge clk) disable iff (rst)
        (pend.busy && pend.kind == BK_DSB) |-> !oth_en);

    assert_store_lets_loads_R3: assert property (@(posedge clk) disable iff (rst)
        (pend.busy && pend.kind != BK_ISB && pend.acc == AC_ST) |-> ld_en);

    assert_flush_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

    assert_flush_cause_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> !pend.busy);
endmodule

// File: tb/membar_ctrl_test.sv
module membar_ctrl_test;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, iss_valid, ack_valid;
    logic [2:0] iss_op;
    logic [1:0] iss_dom, bar_kind, bar_class, ack_class, ack_dom;
    logic ld_en, st_en, mnt_en, oth_en, bar_en, stall, flush;

    membar_ctrl #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dom(iss_dom), .bar_kind(bar_kind), .bar_class(bar_class),
        .ack_valid(ack_valid), .ack_class(ack_class), .ack_dom(ack_dom),
        .ld_en(ld_en), .st_en(st_en), .mnt_en(mnt_en), .oth_en(oth_en),
        .bar_en(bar_en), .stall(stall), .flush(flush)
    );

    int checks = 0, fails = 0, cyc = 0;
    int cnt[4][3];
    bit mp, mfl;
    int mk, mc, md;

    function automatic bit m_en(int op);
        case (op)
            1:       return !mp || (mk != 2 && mc == 1);
            2, 3, 4: return !mp;
            default: return !mp || mk == 0;
        endcase
    endfunction

    function automatic bit m_done();
        if (!mp) return 0;
        for (int d = 0; d < 4; d++)
            for (int c = 0; c < 3; c++) begin
                bit need;
                if (mk == 2) need = (c == 2);
                else need = (d <= md) && (c == 2 || (c == 0 && mc != 1) || (c == 1 && mc != 0));
                if (need && cnt[d][c] != 0) return 0;
            end
        return 1;
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 4; d++)
            for (int c = 0; c < 3; c++) cnt[d][c] = 0;
        mp = 0; mfl = 0; mk = 0; mc = 0; md = 0;
    endtask

    task automatic chk(string tag, string nm, logic got, bit exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d got %b exp %b", tag, nm, cyc, got, exp);
        end
    endtask

    task automatic step(string tag, bit v, int op, int dom, int k, int c,
                        bit av, int ac, int ad);
        bit acc, dn;
        int ic, dc;
        iss_valid = v; iss_op = 3'(op); iss_dom = 2'(dom);
        bar_kind = 2'(k); bar_class = 2'(c);
        ack_valid = av; ack_class = 2'(ac); ack_dom = 2'(ad);
        #4;
        chk(tag, "ld_en",  ld_en,  m_en(1));
        chk(tag, "st_en",  st_en,  m_en(2));
        chk(tag, "mnt_en", mnt_en, m_en(3));
        chk(tag, "oth_en", oth_en, m_en(0));
        chk(tag, "bar_en", bar_en, m_en(4));
        chk(tag, "stall",  stall,  v && !m_en(op));
        chk(tag, "flush",  flush,  mfl);
        acc = v && m_en(op);
        dn  = m_done();
        ic  = (acc && op >= 1 && op <= 3) ? op - 1 : -1;
        dc  = (av && ac < 3) ? ac : -1;
        if (ic >= 0 && dc == ic && ad == dom) begin
            // same counter both ways: unchanged
        end else begin
            if (ic >= 0 && cnt[dom][ic] < CMAX) cnt[dom][ic]++;
            if (dc >= 0 && cnt[ad][dc] > 0)     cnt[ad][dc]--;
        end
        mfl = dn && mk == 2;
        if (dn) mp = 0;
        else if (acc && op == 4) begin
            mp = 1;
            mk = (k == 3) ? 1 : k;
            mc = (c == 3) ? 2 : c;
            md = dom;
        end
        @(posedge clk);
        #5;
    endtask

    task automatic idle(string tag);            step(tag, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic iss(string tag, int op, int d); step(tag, 1, op, d, 0, 0, 0, 0, 0); endtask
    task automatic bar(string tag, int k, int c, int d); step(tag, 1, 4, d, k, c, 0, 0, 0); endtask
    task automatic ack(string tag, int c, int d); step(tag, 0, 0, 0, 0, 0, 1, c, d); endtask

    task automatic do_reset();
        rst = 1; iss_valid = 0; ack_valid = 0; iss_op = 0; iss_dom = 0;
        bar_kind = 0; bar_class = 0; ack_class = 0; ack_dom = 0;
        repeat (2) @(posedge clk);
        #5;
        rst = 0;
        model_reset();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog cycle %0d got running exp finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        idle("R1"); idle("R1");

        // R2: load-class barrier ignores earlier stores
        iss("R2", 1, 1); iss("R2", 1, 1); iss("R2", 2, 1);
        bar("R2", 0, 0, 1);
        iss("R2", 1, 1); iss("R2", 0, 1); iss("R2", 2, 1);
        ack("R2", 0, 1); idle("R2"); ack("R2", 0, 1);
        idle("R2"); idle("R2"); ack("R2", 1, 1); idle("R2");

        // R3: store-class barrier lets loads through
        do_reset();
        iss("R3", 2, 0); iss("R3", 1, 0);
        bar("R3", 0, 1, 0);
        iss("R3", 1, 0); iss("R3", 2, 0);
        ack("R3", 0, 0); ack("R3", 0, 0); idle("R3");
        ack("R3", 1, 0); idle("R3"); idle("R3"); iss("R3", 2, 0);

        // R4: any-class barrier drains both
        do_reset();
        iss("R4", 1, 2); iss("R4", 2, 2);
        bar("R4", 0, 2, 3);
        iss("R4", 2, 2); ack("R4", 1, 2); idle("R4");
        ack("R4", 0, 2); idle("R4"); idle("R4");

        // R5: domain reach
        do_reset();
        iss("R5", 1, 2);
        bar("R5", 0, 2, 0); idle("R5"); idle("R5");
        bar("R5", 0, 2, 1); idle("R5"); idle("R5");
        bar("R5", 0, 2, 3); idle("R5"); idle("R5");
        ack("R5", 0, 2); idle("R5"); idle("R5");

        // R6: memory barrier waits on maintenance, others flow
        do_reset();
        iss("R6", 3, 1);
        bar("R6", 0, 1, 1);
        iss("R6", 0, 0); iss("R6", 2, 1); iss("R6", 3, 1);
        ack("R6", 2, 1); idle("R6"); idle("R6");

        // R7: synchronization barrier holds other ops
        do_reset();
        iss("R7", 2, 3); iss("R7", 3, 0);
        bar("R7", 1, 2, 3);
        iss("R7", 0, 0); ack("R7", 1, 3); iss("R7", 0, 0);
        ack("R7", 2, 0); idle("R7"); idle("R7"); iss("R7", 0, 0);

        // R8: instruction barrier, flush pulse
        do_reset();
        iss("R8", 3, 3); iss("R8", 1, 0);
        bar("R8", 2, 0, 0);
        iss("R8", 1, 0); iss("R8", 0, 0); iss("R8", 3, 0);
        ack("R8", 2, 3); idle("R8"); idle("R8"); idle("R8");
        ack("R8", 0, 0); idle("R8");

        // R9: single pending barrier
        do_reset();
        iss("R9", 1, 0);
        bar("R9", 0, 0, 0); bar("R9", 1, 2, 3);
        ack("R9", 0, 0); bar("R9", 1, 2, 3);
        bar("R9", 2, 0, 0); idle("R9"); idle("R9");

        // R10: same-cycle issue and acknowledge on one counter
        do_reset();
        iss("R10", 1, 0);
        step("R10", 1, 1, 0, 0, 0, 1, 0, 0);
        bar("R10", 0, 0, 0); idle("R10"); idle("R10");
        ack("R10", 0, 0); idle("R10"); idle("R10");
        step("R10", 1, 2, 1, 0, 0, 1, 1, 1);
        bar("R10", 0, 1, 1); idle("R10"); idle("R10");

        // R11: saturation and no underflow
        do_reset();
        for (int i = 0; i < CMAX + 2; i++) iss("R11", 1, 1);
        bar("R11", 0, 0, 1);
        for (int i = 0; i < CMAX - 1; i++) ack("R11", 0, 1);
        idle("R11"); ack("R11", 0, 1); idle("R11"); idle("R11");
        ack("R11", 1, 1); iss("R11", 2, 1);
        bar("R11", 0, 1, 1); idle("R11"); ack("R11", 1, 1); idle("R11"); idle("R11");

        // R12: spare codes
        do_reset();
        iss("R12", 1, 0);
        bar("R12", 0, 3, 0);
        iss("R12", 1, 0); iss("R12", 2, 0); iss("R12", 5, 0);
        ack("R12", 3, 0); idle("R12");
        ack("R12", 0, 0); idle("R12");
        iss("R12", 2, 2);
        bar("R12", 3, 1, 2);
        iss("R12", 7, 0); iss("R12", 1, 0);
        ack("R12", 1, 2); idle("R12"); idle("R12");

        // R1: reset while a barrier is pending
        iss("R1", 1, 3); bar("R1", 1, 2, 3); idle("R1");
        do_reset();
        idle("R1"); bar("R1", 0, 2, 3); idle("R1"); idle("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule